// File: doc/BRIEF.md
# Bridge Deadlock Resolver

This block watches the two slave front ends of a processor-to-peripheral bridge. The upstream slave serves processor-side cycles and the downstream slave serves peripheral-side cycles. Traffic between them passes through two FIFOs, one in each direction. When both slaves report a stall in the same clock cycle, neither can make progress, and the resolver breaks the lock. It always acts on the upstream slave and never on the downstream one.

The action depends on the kind of cycle the upstream slave is serving when the lock is seen. A read of any kind is ended with a retry, any partly fetched read data is dropped, and the pending command is removed from the outbound FIFO. A non-posted write is also retried and its command removed, but no read data is dropped; such a write may already be partly done. A posted write is never retried. The resolver waits for that write to signal completion and then looks at the stall inputs again. A wrapping or saturating event counter and a sticky flag record every lock that is detected.

Top module: `bdr_lock_resolver`

## Requirements
- R1: After reset, up_retry, fifo_flush, rd_discard, busy and lock_seen are 0 and lock_count is 0.
- R2: A lock is detected only when up_stall and dn_stall are both 1 at the same rising edge while busy is 0. A stall on either side alone leaves busy at 0 and produces no pulse.
- R3: For cycle kind 2'b00 or 2'b11 (reads), up_retry, fifo_flush and rd_discard are each 1 for exactly one cycle. That cycle is the second cycle after the detecting edge.
- R4: For cycle kind 2'b10 (non-posted write), up_retry and fifo_flush pulse for exactly one cycle at the same point as in R3, and rd_discard stays 0.
- R5: For cycle kind 2'b01 (posted write), no retry, flush or discard pulse is issued. busy stays 1 until up_wr_done is 1 at a rising edge, and then returns to 0 at that edge.
- R6: After a retry pulse, busy stays 1 until dn_stall is 0 at a rising edge, and then returns to 0 at that edge.
- R7: lock_count rises by one at each detecting edge, for every cycle kind. With the default setting it saturates at all ones. lock_seen becomes 1 at the first detection and stays 1 until reset.
- R8: Both stalls being high while busy is 1 is not a new event: lock_count does not change and no extra pulse is issued.
- R9: The cycle kind is captured at the detecting edge. Changes on up_kind afterwards do not alter how that event is resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_stall | input | 1 | Upstream slave cannot proceed |
| dn_stall | input | 1 | Downstream slave cannot proceed |
| up_kind | input | 2 | Upstream cycle kind: 00 read, 01 posted write, 10 non-posted write, 11 read |
| up_wr_done | input | 1 | Upstream posted write completed |
| up_retry | output | 1 | One-cycle command to end the upstream cycle with a retry |
| fifo_flush | output | 1 | One-cycle command to drop the pending outbound FIFO command |
| rd_discard | output | 1 | One-cycle command to drop partly fetched read data |
| busy | output | 1 | A resolution is in progress |
| lock_count | output | CNT_W | Number of detected locks |
| lock_seen | output | 1 | Sticky: at least one lock detected since reset |

## Verification
The hardest case to reach is a second simultaneous stall, or a change of cycle kind, that arrives while an earlier resolution is still open. It is especially hard to hit during the posted-write wait, where the exit depends on a completion handshake and not on the stalls. Random stimulus holds each stall high about half the time and raises the completion handshake rarely, so these overlaps occur often. Directed sequences hold both stalls high for several cycles through each kind of resolution, and the cycle kind is changed in mid-event. A cycle-level reference model in the bench tracks the expected state, pulses and count through thousands of such cycles, including saturation of the counter.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
   typedef enum logic [1:0] {
      CYC_RD    = 2'b00,
      CYC_PW    = 2'b01,
      CYC_NPW   = 2'b10,
      CYC_RDX   = 2'b11
   } cyc_kind_e;

   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_DETECT  = 3'd1,
      S_BACKOUT = 3'd2,
      S_DRAIN   = 3'd3,
      S_RELEASE = 3'd4
   } res_state_e;

   function automatic logic kind_is_read(input logic [1:0] k);
      return (k == CYC_RD) || (k == CYC_RDX);
   endfunction
endpackage

// File: rtl/bdr_detect.sv
module bdr_detect
   import bdr_pkg::*;
#(
   parameter int KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_stall,
   input  logic              dn_stall,
   input  logic              idle,
   input  logic [KIND_W-1:0] kind_in,
   output logic              lock_evt,
   output logic [KIND_W-1:0] kind_q
);
   if (KIND_W != 2) begin : g_bad_kind
      $error("bdr_detect: KIND_W must be 2");
   end

   assign lock_evt = idle & up_stall & dn_stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        kind_q <= '0;
      else if (lock_evt) kind_q <= kind_in;
   end

   // R9: captured kind only moves at a detection
   p_kind_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(kind_q));
endmodule

// File: rtl/bdr_fsm.sv
module bdr_fsm
   import bdr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lock_evt,
   input  logic [1:0] kind_q,
   input  logic       up_wr_done,
   input  logic       dn_stall,
   output logic       idle,
   output logic       up_retry,
   output logic       fifo_flush,
   output logic       rd_discard
);
   res_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE:    if (lock_evt) st_d = S_DETECT;
         S_DETECT:  st_d = (kind_q == CYC_PW) ? S_DRAIN : S_BACKOUT;
         S_BACKOUT: st_d = S_RELEASE;
         S_DRAIN:   if (up_wr_done) st_d = S_IDLE;
         S_RELEASE: if (!dn_stall) st_d = S_IDLE;
         default:   st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_IDLE;
      else        st_q <= st_d;
   end

   assign idle       = (st_q == S_IDLE);
   assign up_retry   = (st_q == S_BACKOUT);
   assign fifo_flush = (st_q == S_BACKOUT);
   assign rd_discard = (st_q == S_BACKOUT) && kind_is_read(kind_q);

   // R3: retry is a single-cycle pulse
   p_retry_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      up_retry |=> !up_retry);
   // R5: a posted write is never retried
   p_posted_no_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && kind_q == CYC_PW) |-> !up_retry);
   // R6: release ends once the downstream stall drops
   p_release_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RELEASE && !dn_stall) |=> idle);
   // R4: a non-posted write never discards read data
   p_npw_no_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == CYC_NPW) |-> !rd_discard);
endmodule

// File: rtl/bdr_tally.sv
module bdr_tally #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             seen
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("bdr_tally: CNT_W must be 1..32");
   end

   logic [CNT_W-1:0] count_d;

   if (SATURATE) begin : g_sat
      assign count_d = (count == CNT_MAX) ? count : count + 1'b1;
   end else begin : g_wrap
      assign count_d = count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         seen  <= 1'b0;
      end else if (inc) begin
         count <= count_d;
         seen  <= 1'b1;
      end
   end

   // R7: count steps by one below the ceiling
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && count != CNT_MAX) |=> count == $past(count) + 1'b1);
   // R7: sticky flag never clears
   p_seen_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seen |=> seen);
endmodule

// File: rtl/bdr_lock_resolver.sv
module bdr_lock_resolver
   import bdr_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_stall,
   input  logic             dn_stall,
   input  logic [1:0]       up_kind,
   input  logic             up_wr_done,
   output logic             up_retry,
   output logic             fifo_flush,
   output logic             rd_discard,
   output logic             busy,
   output logic [CNT_W-1:0] lock_count,
   output logic             lock_seen
);
   logic       idle;
   logic       lock_evt;
   logic [1:0] kind_q;

   bdr_detect #(.KIND_W(2)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_stall (up_stall),
      .dn_stall (dn_stall),
      .idle     (idle),
      .kind_in  (up_kind),
      .lock_evt (lock_evt),
      .kind_q   (kind_q)
   );

   bdr_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock_evt   (lock_evt),
      .kind_q     (kind_q),
      .up_wr_done (up_wr_done),
      .dn_stall   (dn_stall),
      .idle       (idle),
      .up_retry   (up_retry),
      .fifo_flush (fifo_flush),
      .rd_discard (rd_discard)
   );

   bdr_tally #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (lock_evt),
      .count (lock_count),
      .seen  (lock_seen)
   );

   assign busy = !idle;

   // R2: no single-side stall starts a resolution
   p_single_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(up_stall && dn_stall)) |=> !busy);
   // R2: simultaneous stalls while idle always start one
   p_both_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && up_stall && dn_stall) |=> busy);
   // R8: no new event is counted while busy
   p_no_recount_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(lock_count));
   // R3: flush accompanies every retry
   p_flush_with_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      up_retry |-> (fifo_flush && $past(busy)));
endmodule

// File: tb/bdr_lock_resolver_bench.sv
`timescale 1ns/1ps
module bdr_lock_resolver_bench;
   localparam int CNT_W = 8;
   localparam int MAXC  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_stall = 1'b0, dn_stall = 1'b0, up_wr_done = 1'b0;
   logic [1:0] up_kind = 2'b00;
   logic up_retry, fifo_flush, rd_discard, busy, lock_seen;
   logic [CNT_W-1:0] lock_count;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state: 0 idle,1 detect,2 backout,3 drain,4 release
   int m_st = 0;
   int m_kind = 0;
   int m_cnt = 0;
   int m_seen = 0;

   always #2 clk = ~clk;

   bdr_lock_resolver #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_bdr_lock_resolver (
      .clk(clk), .rst_n(rst_n), .up_stall(up_stall), .dn_stall(dn_stall),
      .up_kind(up_kind), .up_wr_done(up_wr_done), .up_retry(up_retry),
      .fifo_flush(fifo_flush), .rd_discard(rd_discard), .busy(busy),
      .lock_count(lock_count), .lock_seen(lock_seen)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic string kind_tag(input int k);
      if (k == 1) return "R5";
      if (k == 2) return "R4";
      return "R3";
   endfunction

   function automatic string busy_tag(input int s);
      case (s)
         0: return "R2";
         3: return "R5";
         4: return "R6";
         default: return "R3";
      endcase
   endfunction

   task automatic check_model();
      int exp_pulse;
      int exp_disc;
      exp_pulse = (m_st == 2) ? 1 : 0;
      exp_disc  = (m_st == 2 && (m_kind == 0 || m_kind == 3)) ? 1 : 0;
      chk(busy_tag(m_st), "busy", int'(busy), (m_st != 0) ? 1 : 0);
      chk(kind_tag(m_kind), "up_retry", int'(up_retry), exp_pulse);
      chk(kind_tag(m_kind), "fifo_flush", int'(fifo_flush), exp_pulse);
      chk(kind_tag(m_kind), "rd_discard", int'(rd_discard), exp_disc);
      chk((m_st != 0) ? "R8" : "R7", "lock_count", int'(lock_count), m_cnt);
      chk("R7", "lock_seen", int'(lock_seen), m_seen);
   endtask

   task automatic step(input logic us, input logic ds, input logic [1:0] k, input logic wd);
      @(negedge clk);
      check_model();
      up_stall = us; dn_stall = ds; up_kind = k; up_wr_done = wd;
      case (m_st)
         0: if (us && ds) begin
               m_st = 1; m_kind = int'(k); m_seen = 1;
               if (m_cnt < MAXC) m_cnt++;
            end
         1: m_st = (m_kind == 1) ? 3 : 2;
         2: m_st = 4;
         3: if (wd) m_st = 0;
         4: if (!ds) m_st = 0;
         default: m_st = 0;
      endcase
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "up_retry", int'(up_retry), 0);
      chk("R1", "fifo_flush", int'(fifo_flush), 0);
      chk("R1", "rd_discard", int'(rd_discard), 0);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "lock_count", int'(lock_count), 0);
      chk("R1", "lock_seen", int'(lock_seen), 0);
      rst_n = 1'b1;

      // R2: one-sided stalls
      repeat (4) step(1'b1, 1'b0, 2'b00, 1'b0);
      repeat (4) step(1'b0, 1'b1, 2'b10, 1'b0);
      step(1'b0, 1'b0, 2'b00, 1'b0);
      // R3: read lock, stalls held (R8 re-assertion while busy)
      repeat (4) step(1'b1, 1'b1, 2'b00, 1'b0);
      step(1'b0, 1'b0, 2'b00, 1'b0);
      step(1'b0, 1'b0, 2'b00, 1'b0);
      chk("R7", "lock_count after read", int'(lock_count), 1);
      // R3: alternate read code
      step(1'b1, 1'b1, 2'b11, 1'b0);
      repeat (3) step(1'b0, 1'b1, 2'b11, 1'b0);
      step(1'b0, 1'b0, 2'b00, 1'b0);
      // R4 and R9: non-posted write, kind changed mid-event
      step(1'b1, 1'b1, 2'b10, 1'b0);
      repeat (3) step(1'b1, 1'b1, 2'b00, 1'b0);
      step(1'b0, 1'b0, 2'b00, 1'b0);
      step(1'b0, 1'b0, 2'b00, 1'b0);
      // R5: posted write waits for completion, then re-evaluates
      step(1'b1, 1'b1, 2'b01, 1'b0);
      repeat (4) step(1'b1, 1'b1, 2'b01, 1'b0);
      step(1'b1, 1'b1, 2'b01, 1'b1);
      step(1'b1, 1'b1, 2'b00, 1'b0);
      repeat (3) step(1'b0, 1'b0, 2'b00, 1'b0);
      chk("R7", "lock_count directed", int'(lock_count), 5);
      chk("R7", "lock_seen directed", int'(lock_seen), 1);

      // random phase, long enough to saturate the counter
      for (int i = 0; i < 6000; i++) begin
         step(1'(($urandom % 2) == 0), 1'(($urandom % 2) == 0),
              2'($urandom % 4), 1'(($urandom % 4) == 0));
      end
      step(1'b0, 1'b0, 2'b00, 1'b0);
      chk("R7", "lock_count saturated", int'(lock_count), MAXC);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule